// File: doc/BRIEF.md
# Byte-lane asynchronous static RAM controller

This block sits between a simple synchronous request port and an external asynchronous static RAM of 2^18 words by 16 bits. Each accepted request names an address, a read or write direction, two byte enables and (for writes) a data word. The block turns it into the active-low chip-select, write, output-enable, lower-byte and upper-byte pattern the RAM needs. It runs the read and write phases for cycle counts set by parameters and returns read data with a single-cycle valid pulse.

The data bus is split into an output word, an output-enable and an input word. A pad-level tristate buffer outside the block joins them. Every output towards the RAM comes from a flop. Each write is shaped so that the write strobe rising is the only terminating edge. Address, data, chip select and byte strobes are all held across that edge. Output-enable stays high whenever the block drives the bus. A write that directly follows a read gets one extra dead cycle. While no request is pending, chip select is high, which keeps the RAM in its low-power standby.

Top module: `async_sram_ctl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are all 1, and mem_dq_oe is 0.
- R2: A read accepted at edge E0 holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_WAIT cycles. It samples mem_dq_in at the last of those edges and raises rsp_valid for one cycle right after it, with rsp_rdata carrying the sampled word.
- R3: mem_we_n is low only while mem_cs_n is low, mem_oe_n is high and mem_dq_oe is high. The byte strobes follow req_be: bit 0 drives mem_lb_n (bus bits 7:0) and bit 1 drives mem_ub_n (bus bits 15:8), active low.
- R4: In a write, the data is on mem_dq_out with mem_dq_oe high one cycle before mem_we_n falls. mem_we_n stays low for WR_PULSE cycles. For one cycle after it rises, address, data, chip select and byte strobes are held.
- R5: mem_oe_n is high in every cycle in which mem_dq_oe is high.
- R6: A write accepted in the first idle cycle after a read gets one turnaround cycle with the bus released and mem_oe_n high. Its first write-low cycle then comes three cycles after acceptance instead of two.
- R7: req_ready drops in the cycle after a request is accepted and returns only when the access ends. A request presented while req_ready is 0 is ignored.
- R8: In a read with only one byte enabled, the unselected byte of rsp_rdata is zero.
- R9: Whenever the block is idle (req_ready high), mem_cs_n is high and mem_dq_oe is low.
- R10: A write with one byte enabled changes only that byte of the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected byte zero |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | RAM lower byte strobe, active low |
| mem_ub_n | output | 1 | RAM upper byte strobe, active low |
| mem_dq_out | output | 16 | Data driven towards the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data read back from the RAM bus |

## Verification
Every output is a flop, so each result is counted in edges from the accepting edge E0. A read keeps output-enable low in samples 1 through RD_WAIT and shows rsp_valid at sample RD_WAIT+1. A write first pulls the write strobe low at sample 2, or sample 3 when a turnaround is due, and holds it for WR_PULSE samples plus one hold sample. The tasks drive inputs and sample outputs on falling edges. At each sample they count the index and compare it with these figures, so a result one cycle early or late fails. A bench RAM model stores data on the rising write strobe, which lets byte-write and zero-fill results be checked by read-back.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctl_state_t;
endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (load)          count <= load_val;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign zero = (count == '0);

  // R2: once expired, the timer stays expired until reloaded
  p_timer_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        strb_be,
  input  logic [LANES-1:0]        rd_be,
  input  logic [LANES*LANE_W-1:0] bus_in,
  output logic [LANES-1:0]        strb_n,
  output logic [LANES*LANE_W-1:0] rd_merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb_n[g] = ~strb_be[g];
    assign rd_merged[g*LANE_W +: LANE_W] =
      rd_be[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl #(
  parameter int ADDR_W   = 18,
  parameter int LANE_W   = 8,
  parameter int RD_WAIT  = 3,
  parameter int WR_PULSE = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_be,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic                rsp_valid,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_cs_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [2*LANE_W-1:0] mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_in
);
  import sram_ctl_pkg::*;

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int MAX_CT = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
  localparam int TMR_W  = $clog2(MAX_CT + 1);

  ctl_state_t        state;
  logic              after_rd;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  strb_q;
  logic [LANES-1:0]  be_sel;
  logic [LANES-1:0]  strb_n_nx;
  logic [DATA_W-1:0] rd_merged;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic              accept;

  assign accept = (state == ST_IDLE) && req_valid;
  assign be_sel = (state == ST_IDLE) ? req_be : be_q;

  assign tmr_load = (accept && !req_write) || (state == ST_WSETUP);
  assign tmr_val  = (state == ST_WSETUP) ? TMR_W'(WR_PULSE - 1) : TMR_W'(RD_WAIT - 1);

  sram_ctl_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_ctl_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .strb_be   (be_sel),
    .rd_be     (be_q),
    .bus_in    (mem_dq_in),
    .strb_n    (strb_n_nx),
    .rd_merged (rd_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      after_rd   <= 1'b0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      strb_q     <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      be_q       <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            be_q       <= req_be;
            req_ready  <= 1'b0;
            if (!req_write) begin
              state    <= ST_READ;
              mem_cs_n <= 1'b0;
              mem_oe_n <= 1'b0;
              strb_q   <= strb_n_nx;
              after_rd <= 1'b1;
            end else if (after_rd) begin
              state    <= ST_TURN;
              after_rd <= 1'b0;
            end else begin
              state     <= ST_WSETUP;
              mem_cs_n  <= 1'b0;
              strb_q    <= strb_n_nx;
              mem_dq_oe <= 1'b1;
            end
          end else begin
            after_rd <= 1'b0;
          end
        end
        ST_READ: begin
          if (tmr_zero) begin
            state     <= ST_IDLE;
            rsp_rdata <= rd_merged;
            rsp_valid <= 1'b1;
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            strb_q    <= '1;
            req_ready <= 1'b1;
          end
        end
        ST_TURN: begin
          state     <= ST_WSETUP;
          mem_cs_n  <= 1'b0;
          strb_q    <= strb_n_nx;
          mem_dq_oe <= 1'b1;
        end
        ST_WSETUP: begin
          state    <= ST_WPULSE;
          mem_we_n <= 1'b0;
        end
        ST_WPULSE: begin
          if (tmr_zero) begin
            state    <= ST_WHOLD;
            mem_we_n <= 1'b1;
          end
        end
        ST_WHOLD: begin
          state     <= ST_IDLE;
          mem_cs_n  <= 1'b1;
          strb_q    <= '1;
          mem_dq_oe <= 1'b0;
          req_ready <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_lb_n = strb_q[0];
  assign mem_ub_n = strb_q[1];

  // R3: write strobe only inside a selected, bus-driving, output-disabled window
  p_we_window_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));
  // R4: write strobe rise is the terminating edge; everything else held
  p_we_rise_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));
  // R5: never drive the bus while the RAM may drive it
  p_no_contention_r5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
  // R6: bus stays released in the cycle after output-enable was low
  p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |=> !mem_dq_oe);
  // R7: acceptance drops ready
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R2: response valid is a single-cycle pulse
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R9: idle means standby with the bus released
  p_standby_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && !mem_dq_oe));
endmodule

// File: tb/test_async_sram_ctl.sv
`timescale 1ns/1ps
module test_async_sram_ctl;
  localparam int RD_WAIT  = 3;
  localparam int WR_PULSE = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [17:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  async_sram_ctl #(.ADDR_W(18), .LANE_W(8), .RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE)) i_async_sram_ctl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // RAM model: stores on the rising write strobe, floats to A5 when not driving
  logic [7:0] ram_lo [256];
  logic [7:0] ram_hi [256];
  logic       ram_rd;
  assign ram_rd = (mem_cs_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
  assign mem_dq_in[7:0]  = (ram_rd && mem_lb_n === 1'b0) ? ram_lo[mem_addr[7:0]] : 8'hA5;
  assign mem_dq_in[15:8] = (ram_rd && mem_ub_n === 1'b0) ? ram_hi[mem_addr[7:0]] : 8'hA5;

  always @(posedge mem_we_n) begin
    if (mem_cs_n === 1'b0) begin
      if (mem_lb_n === 1'b0) ram_lo[mem_addr[7:0]] <= mem_dq_out[7:0];
      if (mem_ub_n === 1'b0) ram_hi[mem_addr[7:0]] <= mem_dq_out[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R5: contention monitor at every sample
  always @(negedge clk) begin
    if (!rst && !done && mem_dq_oe === 1'b1 && mem_oe_n !== 1'b1) begin
      bad++; total++;
      $display("FAIL R5 actual=%0h expected=%0h", mem_oe_n, 1);
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Called at a falling edge; returns at the falling edge where the block is idle again
  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be, input int exp_lat);
    int n = 1;
    int first = 0;
    int lowcnt = 0;
    bit held = 0;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    while (n < 30 && !held) begin
      if (mem_we_n === 1'b0) begin
        if (first == 0) first = n;
        lowcnt++;
        chk(!mem_cs_n && mem_oe_n && mem_dq_oe, "R3 window", {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b011);
        chk({mem_ub_n, mem_lb_n} == ~be, "R3 strobes", {mem_ub_n, mem_lb_n}, ~be);
        chk(mem_dq_out == d && mem_addr == a, "R4 data", mem_dq_out, d);
      end else if (lowcnt > 0) begin
        held = 1;
        chk(!mem_cs_n && mem_dq_oe && mem_dq_out == d && mem_addr == a && {mem_ub_n, mem_lb_n} == ~be,
            "R4 hold", {mem_cs_n, mem_dq_oe}, 2'b01);
      end else if (n == exp_lat - 1) begin
        chk(mem_dq_oe && mem_dq_out == d, "R4 setup", mem_dq_oe, 1);
      end else if (n < exp_lat - 1) begin
        chk(!mem_dq_oe && mem_oe_n, "R6 turnaround", {mem_dq_oe, mem_oe_n}, 2'b01);
      end
      @(negedge clk); n++;
    end
    chk(first == exp_lat, "R6 write latency", first, exp_lat);
    chk(lowcnt == WR_PULSE, "R4 pulse width", lowcnt, WR_PULSE);
    chk(req_ready && mem_cs_n && !mem_dq_oe, "R9 release", {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be, input logic [15:0] exp);
    int n = 1;
    int oelow = 0;
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 0;
    while (n < 30 && !rsp_valid) begin
      if (mem_oe_n === 1'b0) begin
        oelow++;
        chk(!mem_cs_n && mem_we_n && !mem_dq_oe && mem_addr == a && {mem_ub_n, mem_lb_n} == ~be,
            "R2 read pattern", {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b010);
      end
      chk(!req_ready, "R7 busy", req_ready, 0);
      @(negedge clk); n++;
    end
    chk(n == RD_WAIT + 1, "R2 rsp timing", n, RD_WAIT + 1);
    chk(oelow == RD_WAIT, "R2 oe cycles", oelow, RD_WAIT);
    chk(rsp_rdata == exp, "R2/R8 read data", rsp_rdata, exp);
    chk(req_ready && mem_cs_n && mem_oe_n, "R9 read release", {req_ready, mem_cs_n, mem_oe_n}, 3'b111);
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
        "R1 reset", {req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
        8'b10111110);
  endtask

  task automatic t_full_word();
    do_write(18'h00005, 16'h1234, 2'b11, 2);
    @(negedge clk);
    do_read(18'h00005, 2'b11, 16'h1234);
  endtask

  task automatic t_byte_lanes();
    @(negedge clk);
    do_write(18'h00005, 16'h00AB, 2'b01, 2);   // R10 lower lane only
    do_write(18'h00005, 16'hCD00, 2'b10, 2);   // R10 upper lane only
    @(negedge clk);
    do_read(18'h00005, 2'b11, 16'hCDAB);       // R10
    @(negedge clk);
    do_read(18'h00005, 2'b01, 16'h00AB);       // R8 upper zero-filled
    @(negedge clk);
    do_read(18'h00005, 2'b10, 16'hCD00);       // R8 lower zero-filled
    @(negedge clk);
    do_write(18'h00006, 16'hFFFF, 2'b00, 2);   // R10 no lane enabled
    @(negedge clk);
    do_read(18'h00006, 2'b11, 16'h0000);
  endtask

  task automatic t_turnaround();
    @(negedge clk);
    do_read(18'h00005, 2'b11, 16'hCDAB);
    do_write(18'h00009, 16'h5A5A, 2'b11, 3);   // R6 extra cycle after a read
    do_write(18'h0000A, 16'h6B6B, 2'b11, 2);   // write after write: no extra cycle
    do_read(18'h00009, 2'b11, 16'h5A5A);
    @(negedge clk);
    do_read(18'h0000A, 2'b11, 16'h6B6B);
  endtask

  task automatic t_busy();
    int guard = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 18'h00020; req_wdata = 16'h7777; req_be = 2'b11;
    @(negedge clk);
    chk(!req_ready, "R7 ready low", req_ready, 0);
    req_addr = 18'h00028; req_wdata = 16'hEEEE;  // stray request while busy
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (!req_ready && guard < 30) begin @(negedge clk); guard++; end
    for (int k = 0; k < 4; k++) begin
      chk(mem_cs_n && !mem_dq_oe, "R9 standby", {mem_cs_n, mem_dq_oe}, 2'b10);
      @(negedge clk);
    end
    do_read(18'h00028, 2'b11, 16'h0000);       // R7 stray ignored
    @(negedge clk);
    do_read(18'h00020, 2'b11, 16'h7777);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin ram_lo[i] = 8'h00; ram_hi[i] = 8'h00; end
    rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    @(negedge clk);
    t_full_word();
    t_byte_lanes();
    t_turnaround();
    t_busy();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule